// File: doc/BRIEF.md
# Cache-Mixing Dataset Block Generator

This block turns a block number into one 512-bit dataset block. It keeps eight 64-bit columns. The first column is seeded from the block number and the other seven start at zero. The block then fetches a fixed number of cache lines through an external request/response port, and each fetched line is folded into all eight columns. The first column decides which cache line comes next: the index is that column's value reduced modulo the cache size.

Before each fetched line is mixed in, the first column is replaced by a square-and-subtract diffusion hash of its old value. The hash runs one squaring step per clock on an internal 64x64 multiplier. The reduction modulo the cache size uses a bit-serial unsigned remainder by default. Both of these run while the cache read is outstanding. The cache itself, and the way it is filled, sit outside the block.

A client loads `block_num` and `cache_blocks` and pulses `start`. It then serves one cache request at a time. It reads `result` in the single cycle in which `done` is high.

Top module: `mixgen_top`

## Requirements
- R1: On an accepted `start`, column 0 becomes `block_num` shifted left by two bits (that is, times 4), zero-extended to 64 bits. Columns 1 to 7 become zero.
- R2: Each access raises `req_valid` with `req_idx` equal to the current column 0 modulo `cache_blocks`. `req_valid` and `req_idx` stay unchanged until the cycle in which `req_ready` is high.
- R3: `req_idx` is always below `cache_blocks` while `req_valid` is high. `cache_blocks` must be nonzero.
- R4: The diffusion hash first adds 1613783669344650115 to its input modulo 2^64. It then performs 42 rounds. Each round squares the state into a 128-bit product and sets the state to the low 64 bits minus the high 64 bits, modulo 2^64.
- R5: After the response arrives, column 0 becomes the hash of its value from before the request, XOR the line's bits [63:0]. Column i (i = 1..7) is XORed with line bits [64i+63:64i].
- R6: Exactly 16 request handshakes take place per generated block. Exactly one response, marked by `rsp_valid`, is consumed after each handshake.
- R7: `done` is high for exactly one cycle. In that cycle `result` holds column 0 in bits [63:0], up to column 7 in bits [511:448].
- R8: A `start` that arrives while a block is in progress is ignored. The block in progress completes with an unchanged result.
- R9: After reset, `done` and `req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a block; accepted only when idle |
| block_num | input | 32 | Block number, sampled with an accepted start |
| cache_blocks | input | 32 | Number of cache lines (nonzero), held stable during a block |
| req_valid | output | 1 | Cache read request valid |
| req_ready | input | 1 | Cache accepts the request |
| req_idx | output | 32 | Cache line index |
| rsp_valid | input | 1 | Cache line data valid |
| rsp_data | input | 512 | Cache line, 64-bit word w in bits [64w+63:64w] |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | 512 | Generated block, column 0 in the low bits |

## Verification
A request first appears 66 clock edges after `start` is accepted, because the bit-serial remainder takes 64 cycles. The hash needs 42 cycles after each launch. The mix lands on the first edge at which both the line and the hash are ready. The bench does not count these latencies. It waits on `req_valid` and `done` and samples at the falling edge. Each index is checked in the cycle its handshake completes, `result` is checked in the cycle `done` is seen, and the bench checks that `done` is low again one cycle later.

// File: rtl/mixgen_pkg.sv
package mixgen_pkg;
   localparam logic [63:0] SQH_OFFSET = 64'd1613783669344650115;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LAUNCH,
      ST_MOD,
      ST_REQ,
      ST_RSP,
      ST_MIX
   } mix_state_e;
endpackage

// File: rtl/mixgen_sqhash.sv
// Iterative square-and-subtract diffusion hash, one round per clock.
module mixgen_sqhash #(
   parameter int W      = 64,
   parameter int ROUNDS = 42
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         kick,
   input  logic [W-1:0] seed,
   output logic         busy,
   output logic [W-1:0] digest
);
   import mixgen_pkg::*;
   localparam int CNT_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

   logic [W-1:0]     st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [2*W-1:0]   sq;

   if (W != 64) begin : g_bad_width
      $error("mixgen_sqhash: W must be 64");
   end

   always_comb sq = (2*W)'(st_q) * (2*W)'(st_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= '0;
         cnt_q <= '0;
         busy  <= 1'b0;
      end else if (kick) begin
         st_q  <= seed + SQH_OFFSET;
         cnt_q <= '0;
         busy  <= 1'b1;
      end else if (busy) begin
         st_q  <= sq[W-1:0] - sq[2*W-1:W];
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == CNT_W'(ROUNDS - 1)) busy <= 1'b0;
      end
   end

   assign digest = st_q;
endmodule

// File: rtl/mixgen_rem.sv
// Unsigned remainder num % den; SERIAL picks bit-serial or single-cycle form.
module mixgen_rem #(
   parameter int NUM_W  = 64,
   parameter int DEN_W  = 32,
   parameter bit SERIAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kick,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             done,
   output logic [DEN_W-1:0] rem
);
   if (DEN_W > NUM_W) begin : g_bad_den
      $error("mixgen_rem: DEN_W must not exceed NUM_W");
   end

   if (SERIAL) begin : g_serial
      localparam int BC_W = $clog2(NUM_W);
      logic [DEN_W-1:0] acc_q;
      logic [NUM_W-1:0] sh_q;
      logic [BC_W-1:0]  bc_q;
      logic             run_q;
      logic [DEN_W:0]   trial;
      logic [DEN_W:0]   trial_sub;

      always_comb begin
         trial     = {acc_q, sh_q[NUM_W-1]};
         trial_sub = trial - {1'b0, den};
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_q <= '0;
            sh_q  <= '0;
            bc_q  <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
         end else begin
            done <= 1'b0;
            if (kick) begin
               acc_q <= '0;
               sh_q  <= num;
               bc_q  <= '0;
               run_q <= 1'b1;
            end else if (run_q) begin
               acc_q <= (trial >= {1'b0, den}) ? trial_sub[DEN_W-1:0] : trial[DEN_W-1:0];
               sh_q  <= sh_q << 1;
               bc_q  <= bc_q + 1'b1;
               if (bc_q == BC_W'(NUM_W - 1)) begin
                  run_q <= 1'b0;
                  done  <= 1'b1;
               end
            end
         end
      end
      assign rem = acc_q;
   end else begin : g_parallel
      logic [DEN_W-1:0] rem_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rem_q <= '0;
            done  <= 1'b0;
         end else begin
            done <= kick;
            if (kick) rem_q <= DEN_W'(num % NUM_W'(den));
         end
      end
      assign rem = rem_q;
   end
endmodule

// File: rtl/mixgen_top.sv
module mixgen_top #(
   parameter int BNUM_W      = 32,
   parameter int IDX_W       = 32,
   parameter int COL_W       = 64,
   parameter int NCOLS       = 8,
   parameter int ACCESSES    = 16,
   parameter int HASH_ROUNDS = 42,
   parameter bit SERIAL_REM  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [BNUM_W-1:0]        block_num,
   input  logic [IDX_W-1:0]         cache_blocks,
   output logic                     req_valid,
   input  logic                     req_ready,
   output logic [IDX_W-1:0]         req_idx,
   input  logic                     rsp_valid,
   input  logic [NCOLS*COL_W-1:0]   rsp_data,
   output logic                     done,
   output logic [NCOLS*COL_W-1:0]   result
);
   import mixgen_pkg::*;
   localparam int ACC_W = $clog2(ACCESSES + 1);

   if (COL_W != 64) begin : g_bad_col
      $error("mixgen_top: COL_W must be 64");
   end
   if (BNUM_W > COL_W - 2) begin : g_bad_bnum
      $error("mixgen_top: BNUM_W too wide for the seed column");
   end
   if (IDX_W > COL_W) begin : g_bad_idx
      $error("mixgen_top: IDX_W wider than a column");
   end
   if (ACCESSES < 1 || NCOLS < 1) begin : g_bad_count
      $error("mixgen_top: ACCESSES and NCOLS must be positive");
   end

   mix_state_e                   state_q;
   logic [NCOLS-1:0][COL_W-1:0]  cols_q;
   logic [NCOLS-1:0][COL_W-1:0]  line_q;
   logic [NCOLS-1:0][COL_W-1:0]  mixed;
   logic [IDX_W-1:0]             idx_q;
   logic [ACC_W-1:0]             acc_q;
   logic                         done_q;
   logic                         kick;
   logic                         hash_busy;
   logic [COL_W-1:0]             hash_out;
   logic                         rem_done;
   logic [IDX_W-1:0]             rem_out;

   assign kick = (state_q == ST_LAUNCH);

   mixgen_sqhash #(.W(COL_W), .ROUNDS(HASH_ROUNDS)) u_hash (
      .clk    (clk),
      .rst_n  (rst_n),
      .kick   (kick),
      .seed   (cols_q[0]),
      .busy   (hash_busy),
      .digest (hash_out)
   );

   mixgen_rem #(.NUM_W(COL_W), .DEN_W(IDX_W), .SERIAL(SERIAL_REM)) u_rem (
      .clk   (clk),
      .rst_n (rst_n),
      .kick  (kick),
      .num   (cols_q[0]),
      .den   (cache_blocks),
      .done  (rem_done),
      .rem   (rem_out)
   );

   // Column 0 takes the hash before the line is folded in; others just fold.
   for (genvar i = 0; i < NCOLS; i++) begin : g_mix
      if (i == 0) begin : g_head
         assign mixed[i] = hash_out ^ line_q[i];
      end else begin : g_tail
         assign mixed[i] = cols_q[i] ^ line_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cols_q  <= '0;
         line_q  <= '0;
         idx_q   <= '0;
         acc_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start) begin
               cols_q    <= '0;
               cols_q[0] <= COL_W'({block_num, 2'b00});
               acc_q     <= '0;
               state_q   <= ST_LAUNCH;
            end
            ST_LAUNCH: state_q <= ST_MOD;
            ST_MOD: if (rem_done) begin
               idx_q   <= rem_out;
               state_q <= ST_REQ;
            end
            ST_REQ: if (req_ready) state_q <= ST_RSP;
            ST_RSP: if (rsp_valid) begin
               line_q  <= rsp_data;
               state_q <= ST_MIX;
            end
            ST_MIX: if (!hash_busy) begin
               cols_q <= mixed;
               if (acc_q == ACC_W'(ACCESSES - 1)) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  acc_q   <= acc_q + 1'b1;
                  state_q <= ST_LAUNCH;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_valid = (state_q == ST_REQ);
   assign req_idx   = idx_q;
   assign done      = done_q;
   assign result    = cols_q;
endmodule

// File: rtl/mixgen_chk.sv
module mixgen_chk #(
   parameter int IDX_W    = 32,
   parameter int ACCESSES = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [IDX_W-1:0] cache_blocks,
   input logic             req_valid,
   input logic             req_ready,
   input logic [IDX_W-1:0] req_idx,
   input logic             done
);
   localparam int HS_W = $clog2(ACCESSES + 1) + 1;
   logic            run_q;
   logic [HS_W-1:0] hs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         hs_q  <= '0;
      end else if (start && (!run_q || done)) begin
         run_q <= 1'b1;
         hs_q  <= '0;
      end else begin
         if (done) run_q <= 1'b0;
         if (req_valid && req_ready) hs_q <= hs_q + 1'b1;
      end
   end

   assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_idx));

   assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> req_idx < cache_blocks);

   assert_access_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> hs_q == HS_W'(ACCESSES));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> !req_valid);

   always_comb begin
      if (!rst_n) assert_reset_state_R9: assert (!done && !req_valid);
   end
endmodule

bind mixgen_top mixgen_chk #(.IDX_W(IDX_W), .ACCESSES(ACCESSES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .cache_blocks (cache_blocks),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .req_idx      (req_idx),
   .done         (done)
);

// File: tb/mixgen_top_bench.sv
module mixgen_top_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [31:0]  block_num = '0;
   logic [31:0]  cache_blocks = 32'd1;
   logic         req_valid;
   logic         req_ready = 1'b0;
   logic [31:0]  req_idx;
   logic         rsp_valid = 1'b0;
   logic [511:0] rsp_data = '0;
   logic         done;
   logic [511:0] result;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   logic [31:0]  exp_idx [16];
   logic [511:0] exp_res;

   always #5 clk = ~clk;

   mixgen_top u_mixgen_top (
      .clk(clk), .rst_n(rst_n), .start(start), .block_num(block_num),
      .cache_blocks(cache_blocks), .req_valid(req_valid), .req_ready(req_ready),
      .req_idx(req_idx), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .done(done), .result(result)
   );

   function automatic logic [63:0] hash_ref(input logic [63:0] x);
      logic [63:0]  s;
      logic [127:0] p;
      s = x + 64'd1613783669344650115;
      for (int r = 0; r < 42; r++) begin
         p = 128'(s) * 128'(s);
         s = p[63:0] - p[127:64];
      end
      return s;
   endfunction

   function automatic logic [511:0] cache_line(input logic [31:0] idx);
      logic [511:0] l;
      for (int w = 0; w < 8; w++)
         l[64*w +: 64] = ({idx, 32'(w)} * 64'h9E3779B97F4A7C15) ^ (64'(w + 1) << 52);
      return l;
   endfunction

   task automatic model(input logic [31:0] bn, input logic [31:0] cb);
      logic [63:0]  c [8];
      logic [511:0] l;
      for (int i = 0; i < 8; i++) c[i] = '0;
      c[0] = {30'd0, bn, 2'b00};
      for (int a = 0; a < 16; a++) begin
         exp_idx[a] = 32'(c[0] % 64'(cb));
         l = cache_line(exp_idx[a]);
         c[0] = hash_ref(c[0]);
         for (int i = 0; i < 8; i++) c[i] = c[i] ^ l[64*i +: 64];
      end
      for (int i = 0; i < 8; i++) exp_res[64*i +: 64] = c[i];
   endtask

   task automatic check(input bit ok, input string what, input logic [511:0] act, input logic [511:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
      end
   endtask

   task automatic run_block(input logic [31:0] bn, input logic [31:0] cb, input bit poke_busy);
      model(bn, cb);
      @(negedge clk);
      block_num = bn; cache_blocks = cb; start = 1'b1;
      @(negedge clk);
      start = 1'b0; block_num = ~bn;
      for (int a = 0; a < 16; a++) begin
         while (!req_valid) @(negedge clk);
         repeat ($urandom_range(0, 3)) @(negedge clk);
         // R2: index equals column 0 modulo the cache size; R3 range
         check(req_valid && req_idx == exp_idx[a], "R2 R3 request index", 512'(req_idx), 512'(exp_idx[a]));
         req_ready = 1'b1;
         @(negedge clk);
         req_ready = 1'b0;
         repeat ($urandom_range(0, 3)) @(negedge clk);
         rsp_valid = 1'b1;
         rsp_data = cache_line(exp_idx[a]);
         if (poke_busy && a == 5) begin
            start = 1'b1;           // R8: must be ignored
            block_num = bn ^ 32'h5A5A_0F0F;
            cache_blocks = cb;
         end
         @(negedge clk);
         rsp_valid = 1'b0;
         start = 1'b0;
      end
      while (!done) @(negedge clk);
      check(result == exp_res, poke_busy ? "R8 R1 R4 R5 R7 result with busy start" : "R1 R4 R5 R6 R7 result",
            result, exp_res);
      @(negedge clk);
      check(!done, "R7 done one cycle", 512'(done), 512'd0);
      check(!req_valid, "R6 no extra request", 512'(req_valid), 512'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog R6 actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (4) @(negedge clk);
      check(!done && !req_valid, "R9 reset outputs", {510'd0, done, req_valid}, 512'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!done && !req_valid, "R9 idle after reset", {510'd0, done, req_valid}, 512'd0);
      run_block(32'd0, 32'd1, 1'b0);
      run_block(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
      run_block(32'd12345, 32'd7, 1'b1);
      run_block(32'd1, 32'd2, 1'b0);
      for (int n = 0; n < 10; n++) begin
         logic [31:0] cb;
         cb = (n % 2 == 0) ? 32'($urandom_range(1, 5000)) : ($urandom | 32'd1);
         run_block($urandom, cb, n == 3);
      end
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule